// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block is the byte-wide host side of a floppy disk controller. The host sees four byte registers on a two-bit select: a main status byte, a data byte, a drive control byte and an interrupt status byte. Command bytes go into the data register. The low five bits of the first byte pick an entry in a 32-entry table. Each entry gives the number of command bytes to collect and the number of result bytes to return.

After the last command byte, the block spends one clock in an execution step. This step is a stub: it updates the controller's status and its cylinder, head, sector and size records, and it fills a result buffer. The host then reads the result bytes back one at a time through the data register. Two status flags tell the host whether the block accepts or presents a byte, and in which direction.

The drive control byte has three jobs. It drives the drive-select, motor and DMA/interrupt-enable outputs. Its reset bit holds the sequencer in reset. Releasing that bit performs a soft reset and may raise the interrupt.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After the reset input: the status byte (select 0) reads 0x80, the interrupt status byte (select 3) reads 0x00, `irq` is low, and all control outputs are zero.
- R2: Only the low five bits of the first command byte select the opcode. Lengths as (command, result): 0x02, 0x05, 0x06, 0x09, 0x0C, 0x11, 0x19, 0x1D are (9,7); 0x0D is (6,7); 0x0A is (2,7); 0x03 and 0x0F are (3,0); 0x07 is (2,0); 0x04 is (2,1); 0x08 is (1,2). Every other opcode is (1,1).
- R3: A data write while idle starts a new command and is stored as byte 0. While bytes are still expected, status reads 0x80: request bit 7 set, direction bit 6 clear.
- R4: The data write that completes a command is followed by one clock with status 0x00. The next clock shows status 0xC0 if the result length is nonzero, or 0x80 if it is zero.
- R5: In the result phase, each data read returns the next result byte in order. After the last byte the block is idle with status 0x80.
- R6: Data writes in the execution or result phase are ignored. A data read outside the result phase returns 0x00 and changes nothing.
- R7: Writing the control byte (select 2) sets `drv_sel` from bits 1:0, `dma_irq_en` from bit 3 and `motor_on` from bits 7:4. Select 2 reads 0x00.
- R8: Writing the control byte with bit 2 clear enters reset and lowers `irq`. A later write with bit 2 set performs a soft reset: the phase goes idle, the status byte becomes 0x80 and ST0 is cleared. That write raises `irq` only when its drive select is 0. The interrupt status byte reads 0xC0 while `irq` is high and 0x00 otherwise.
- R9: An invalid opcode returns a single result byte 0x80 (invalid-command code) and sets ST0 to 0x80.
- R10: Seek (0x0F) sets the cylinder to command byte 2, the head to bit 2 of byte 1, and ST0 to 0x20. Recalibrate (0x07) sets the cylinder to 0 and ORs 0x20 into ST0. Sense-interrupt (0x08) returns ST0 and then the cylinder.
- R11: The (9,7) commands and format (0x0D) take C, H, R, N from command bytes 2 to 5. They advance R by one. When R passes SECTORS it becomes 1 and H increments; when H reaches HEADS it becomes 0 and C increments; C wraps to 0 at CYLINDERS. They return 0, 0, 0, C, H, R, N and store C, H, R, N. Read-ID (0x0A) returns 0, 0, 0 and the stored C, H, R, N.
- R12: Specify (0x03) returns no result bytes. Sense-drive-status (0x04) returns a single 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 status, 1 data, 2 control, 3 interrupt status |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; consumes a result byte when the data register is selected |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Pending interrupt flag |
| drv_sel | output | 2 | Drive select field |
| motor_on | output | 4 | Motor enable field |
| dma_irq_en | output | 1 | DMA/interrupt enable field |

## Verification
The bench builds the block with a geometry of 4 sectors, 2 heads and 3 cylinders. With that geometry, one data-transfer command that starts on the last sector of the last head carries the sector, head and cylinder wrap in a single step. The wrap paths of R11 are therefore exercised with short stimulus. A behavioural model built on queues is compared with every output and with the selected read byte on every clock. This covers the one-clock execution window, the result draining and the soft reset cancelling a half-collected command.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    localparam int OPC_W     = 5;
    localparam int NUM_OPS   = 1 << OPC_W;
    localparam int CMD_BYTES = 9;
    localparam int RES_BYTES = 7;
    localparam int WLEN_W    = $clog2(CMD_BYTES + 1);
    localparam int RLEN_W    = $clog2(RES_BYTES + 1);
    localparam int CNT_W     = WLEN_W;
    localparam int RIDX_W    = $clog2(RES_BYTES);

    // register selects
    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_DATA   = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_IRQ    = 2'd3;

    // control byte field positions
    localparam int DRV_W     = 2;
    localparam int NRST_BIT  = 2;
    localparam int DMA_BIT   = 3;
    localparam int MOTOR_LSB = 4;
    localparam int MOTOR_W   = 4;

    // status byte bits and codes
    localparam int STAT_REQ_BIT = 7;
    localparam int STAT_DIR_BIT = 6;
    localparam logic [7:0] ST0_SEEK_END = 8'h20;
    localparam logic [7:0] ST0_BAD_CMD  = 8'h80;
    localparam logic [7:0] IRQ_PENDING  = 8'hC0;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_e;

    typedef enum logic [2:0] {
        OP_INVALID, OP_XFER, OP_SPECIFY, OP_SENSE_DRV,
        OP_RECAL, OP_SENSE_INT, OP_READ_ID, OP_SEEK
    } op_kind_e;

    typedef struct packed {
        logic [WLEN_W-1:0] wlen;
        logic [RLEN_W-1:0] rlen;
        op_kind_e          kind;
    } op_desc_t;

    typedef struct packed {
        phase_e                       phase;
        logic [CNT_W-1:0]             cnt;
        op_desc_t                     desc;
        logic [CMD_BYTES-1:0][7:0]    cmd;
        logic [RES_BYTES-1:0][7:0]    res;
        byte_t                        st0;
        byte_t                        cyl;
        byte_t                        head;
        byte_t                        rec;
        byte_t                        num;
    } seq_state_t;

    function automatic op_desc_t op_lookup(input logic [OPC_W-1:0] opc);
        op_desc_t d;
        d = '{wlen: WLEN_W'(1), rlen: RLEN_W'(1), kind: OP_INVALID};
        case (opc)
            5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D:
                d = '{wlen: WLEN_W'(9), rlen: RLEN_W'(7), kind: OP_XFER};
            5'h0D: d = '{wlen: WLEN_W'(6), rlen: RLEN_W'(7), kind: OP_XFER};
            5'h0A: d = '{wlen: WLEN_W'(2), rlen: RLEN_W'(7), kind: OP_READ_ID};
            5'h03: d = '{wlen: WLEN_W'(3), rlen: RLEN_W'(0), kind: OP_SPECIFY};
            5'h0F: d = '{wlen: WLEN_W'(3), rlen: RLEN_W'(0), kind: OP_SEEK};
            5'h07: d = '{wlen: WLEN_W'(2), rlen: RLEN_W'(0), kind: OP_RECAL};
            5'h04: d = '{wlen: WLEN_W'(2), rlen: RLEN_W'(1), kind: OP_SENSE_DRV};
            5'h08: d = '{wlen: WLEN_W'(1), rlen: RLEN_W'(2), kind: OP_SENSE_INT};
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fdc_op_table.sv
module fdc_op_table
    import fdc_seq_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output op_desc_t         desc_o
);

    op_desc_t tbl [NUM_OPS];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_entry
        assign tbl[i] = op_lookup(OPC_W'(i));
    end

    assign desc_o = tbl[opc_i];

endmodule

// File: rtl/fdc_exec_unit.sv
module fdc_exec_unit
    import fdc_seq_pkg::*;
#(
    parameter int SECTORS   = 18,
    parameter int HEADS     = 2,
    parameter int CYLINDERS = 80
)(
    input  op_kind_e                  kind_i,
    input  logic [CMD_BYTES-1:0][7:0] cmd_i,
    input  byte_t                     st0_i,
    input  byte_t                     cyl_i,
    input  byte_t                     head_i,
    input  byte_t                     rec_i,
    input  byte_t                     num_i,
    output logic [RES_BYTES-1:0][7:0] res_o,
    output byte_t                     st0_o,
    output byte_t                     cyl_o,
    output byte_t                     head_o,
    output byte_t                     rec_o,
    output byte_t                     num_o
);

    localparam byte_t REC_PAST = 8'(SECTORS + 1);
    localparam byte_t HEAD_END = 8'(HEADS);
    localparam byte_t CYL_END  = 8'(CYLINDERS);

    byte_t c_n, h_n, r_n;
    logic  unused_bits;

    assign unused_bits = ^cmd_i;

    // sector advance over the command's C/H/R
    always_comb begin
        c_n = cmd_i[2];
        h_n = cmd_i[3];
        r_n = cmd_i[4] + 8'd1;
        if (r_n == REC_PAST) begin
            r_n = 8'd1;
            h_n = h_n + 8'd1;
            if (h_n == HEAD_END) begin
                h_n = 8'd0;
                c_n = c_n + 8'd1;
                if (c_n == CYL_END) c_n = 8'd0;
            end
        end
    end

    always_comb begin
        res_o  = '0;
        st0_o  = st0_i;
        cyl_o  = cyl_i;
        head_o = head_i;
        rec_o  = rec_i;
        num_o  = num_i;
        case (kind_i)
            OP_XFER: begin
                st0_o  = 8'd0;
                cyl_o  = c_n;
                head_o = h_n;
                rec_o  = r_n;
                num_o  = cmd_i[5];
                res_o[3] = c_n;
                res_o[4] = h_n;
                res_o[5] = r_n;
                res_o[6] = cmd_i[5];
            end
            OP_READ_ID: begin
                st0_o    = 8'd0;
                res_o[3] = cyl_i;
                res_o[4] = head_i;
                res_o[5] = rec_i;
                res_o[6] = num_i;
            end
            OP_SEEK: begin
                cyl_o  = cmd_i[2];
                head_o = {7'd0, cmd_i[1][2]};
                st0_o  = ST0_SEEK_END;
            end
            OP_RECAL: begin
                cyl_o = 8'd0;
                st0_o = st0_i | ST0_SEEK_END;
            end
            OP_SENSE_INT: begin
                res_o[0] = st0_i;
                res_o[1] = cyl_i;
            end
            OP_SENSE_DRV: res_o[0] = 8'd0;
            OP_SPECIFY:   ;
            default: begin
                st0_o    = ST0_BAD_CMD;
                res_o[0] = ST0_BAD_CMD;
            end
        endcase
    end

endmodule

// File: rtl/fdc_out_reg.sv
module fdc_out_reg
    import fdc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  byte_t              wdata_i,
    output logic [DRV_W-1:0]   drv_sel_o,
    output logic [MOTOR_W-1:0] motor_o,
    output logic               dma_en_o,
    output logic               irq_o,
    output logic               soft_rst_o
);

    typedef struct packed {
        logic               in_rst;
        logic               irq;
        logic [DRV_W-1:0]   drv;
        logic [MOTOR_W-1:0] motor;
        logic               dma;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    assign soft_rst_o = wr_i && wdata_i[NRST_BIT] && ctl_q.in_rst;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d.drv   = wdata_i[DRV_W-1:0];
            ctl_d.dma   = wdata_i[DMA_BIT];
            ctl_d.motor = wdata_i[MOTOR_LSB +: MOTOR_W];
            if (wdata_i[NRST_BIT]) begin
                if (ctl_q.in_rst) begin
                    ctl_d.in_rst = 1'b0;
                    ctl_d.irq    = (wdata_i[DRV_W-1:0] == '0);
                end
            end else if (!ctl_q.in_rst) begin
                ctl_d.in_rst = 1'b1;
                ctl_d.irq    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign drv_sel_o = ctl_q.drv;
    assign motor_o   = ctl_q.motor;
    assign dma_en_o  = ctl_q.dma;
    assign irq_o     = ctl_q.irq;

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[NRST_BIT] && ctl_q.in_rst && wdata_i[DRV_W-1:0] == '0) |=> irq_o);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[NRST_BIT]) |=> !irq_o);

    // R7
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(drv_sel_o) && $stable(motor_o) && $stable(dma_en_o)));

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int SECTORS   = 18,
    parameter int HEADS     = 2,
    parameter int CYLINDERS = 80
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   reg_sel,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [7:0]   wr_data,
    output logic [7:0]   rd_data,
    output logic         irq,
    output logic [1:0]   drv_sel,
    output logic [3:0]   motor_on,
    output logic         dma_irq_en
);

    seq_state_t q, n;

    logic data_wr, data_rd, ctrl_wr, soft_rst;
    op_desc_t tbl_desc;
    logic [RES_BYTES-1:0][7:0] ex_res;
    byte_t ex_st0, ex_cyl, ex_head, ex_rec, ex_num;
    logic [CNT_W-1:0]  idx_c, nxt_c;
    logic [WLEN_W-1:0] wlen_c;

    assign data_wr = wr_en && (reg_sel == SEL_DATA);
    assign data_rd = rd_en && (reg_sel == SEL_DATA);
    assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);

    fdc_op_table u_tbl (
        .opc_i  (wr_data[OPC_W-1:0]),
        .desc_o (tbl_desc)
    );

    fdc_exec_unit #(
        .SECTORS   (SECTORS),
        .HEADS     (HEADS),
        .CYLINDERS (CYLINDERS)
    ) u_exec (
        .kind_i (q.desc.kind),
        .cmd_i  (q.cmd),
        .st0_i  (q.st0),
        .cyl_i  (q.cyl),
        .head_i (q.head),
        .rec_i  (q.rec),
        .num_i  (q.num),
        .res_o  (ex_res),
        .st0_o  (ex_st0),
        .cyl_o  (ex_cyl),
        .head_o (ex_head),
        .rec_o  (ex_rec),
        .num_o  (ex_num)
    );

    fdc_out_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ctrl_wr),
        .wdata_i    (wr_data),
        .drv_sel_o  (drv_sel),
        .motor_o    (motor_on),
        .dma_en_o   (dma_irq_en),
        .irq_o      (irq),
        .soft_rst_o (soft_rst)
    );

    always_comb begin
        n      = q;
        idx_c  = (q.phase == PH_IDLE) ? '0 : q.cnt;
        wlen_c = (q.phase == PH_IDLE) ? tbl_desc.wlen : q.desc.wlen;
        nxt_c  = (q.phase == PH_RES) ? q.cnt + 1'b1 : idx_c + 1'b1;
        if (soft_rst) begin
            n.phase = PH_IDLE;
            n.cnt   = '0;
            n.st0   = 8'd0;
        end else begin
            case (q.phase)
                PH_IDLE, PH_CMD: begin
                    if (data_wr) begin
                        if (q.phase == PH_IDLE) n.desc = tbl_desc;
                        n.cmd[idx_c] = wr_data;
                        if (nxt_c == CNT_W'(wlen_c)) begin
                            n.phase = PH_EXEC;
                            n.cnt   = '0;
                        end else begin
                            n.phase = PH_CMD;
                            n.cnt   = nxt_c;
                        end
                    end
                end
                PH_EXEC: begin
                    n.res   = ex_res;
                    n.st0   = ex_st0;
                    n.cyl   = ex_cyl;
                    n.head  = ex_head;
                    n.rec   = ex_rec;
                    n.num   = ex_num;
                    n.cnt   = '0;
                    n.phase = (q.desc.rlen != '0) ? PH_RES : PH_IDLE;
                end
                default: begin
                    if (data_rd) begin
                        if (nxt_c == CNT_W'(q.desc.rlen)) begin
                            n.cnt   = '0;
                            n.phase = PH_IDLE;
                        end else begin
                            n.cnt = nxt_c;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        rd_data = 8'd0;
        case (reg_sel)
            SEL_STATUS: begin
                rd_data[STAT_REQ_BIT] = (q.phase != PH_EXEC);
                rd_data[STAT_DIR_BIT] = (q.phase == PH_RES);
            end
            SEL_DATA: if (q.phase == PH_RES) rd_data = q.res[q.cnt[RIDX_W-1:0]];
            SEL_IRQ:  rd_data = irq ? IRQ_PENDING : 8'd0;
            default:  ;
        endcase
    end

    // R4
    exec_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_EXEC) |=> (q.phase != PH_EXEC));

    // R6
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_EXEC || q.phase == PH_RES) && data_wr) |=> $stable(q.cmd));

    // R5
    last_result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RES && data_rd && !soft_rst &&
         (q.cnt + 1'b1) == CNT_W'(q.desc.rlen)) |=> (q.phase == PH_IDLE && q.cnt == '0));

    // R8
    soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q.phase == PH_IDLE && q.st0 == 8'd0));

    // R10
    seek_cyl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_EXEC && q.desc.kind == OP_SEEK && !soft_rst)
            |=> (q.cyl == $past(q.cmd[2])));

endmodule

// File: tb/sim_fdc_cmd_seq.sv
`timescale 1ns/1ps
module sim_fdc_cmd_seq;

    localparam int SECT = 4;
    localparam int HDS  = 2;
    localparam int CYLS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;
    logic [1:0] drv_sel;
    logic [3:0] motor_on;
    logic       dma_irq_en;

    always #10 clk = ~clk;

    fdc_cmd_seq #(.SECTORS(SECT), .HEADS(HDS), .CYLINDERS(CYLS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .drv_sel(drv_sel),
        .motor_on(motor_on), .dma_irq_en(dma_irq_en)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_phase;            // 0 idle, 1 collecting, 2 executing, 3 results
    int m_opc, m_wlen, m_rlen, m_cnt;
    int m_cmd[9];
    int m_res[$];
    int m_st0, m_cyl, m_head, m_rec, m_num;
    bit m_irq, m_inrst;
    int m_drv, m_motor, m_dma;
    bit m_sr;

    function automatic void m_lens(int op);
        case (op)
            'h02, 'h05, 'h06, 'h09, 'h0C, 'h11, 'h19, 'h1D: begin m_wlen = 9; m_rlen = 7; end
            'h0D: begin m_wlen = 6; m_rlen = 7; end
            'h0A: begin m_wlen = 2; m_rlen = 7; end
            'h03, 'h0F: begin m_wlen = 3; m_rlen = 0; end
            'h07: begin m_wlen = 2; m_rlen = 0; end
            'h04: begin m_wlen = 2; m_rlen = 1; end
            'h08: begin m_wlen = 1; m_rlen = 2; end
            default: begin m_wlen = 1; m_rlen = 1; end
        endcase
    endfunction

    function automatic void m_exec();
        int c, h, r;
        m_res.delete();
        case (m_opc)
            'h0F: begin m_cyl = m_cmd[2]; m_head = (m_cmd[1] >> 2) & 1; m_st0 = 'h20; end
            'h07: begin m_cyl = 0; m_st0 = m_st0 | 'h20; end
            'h08: begin m_res.push_back(m_st0); m_res.push_back(m_cyl); end
            'h04: m_res.push_back(0);
            'h03: ;
            'h0A: begin
                m_st0 = 0;
                m_res.push_back(0); m_res.push_back(0); m_res.push_back(0);
                m_res.push_back(m_cyl); m_res.push_back(m_head);
                m_res.push_back(m_rec); m_res.push_back(m_num);
            end
            'h02, 'h05, 'h06, 'h09, 'h0C, 'h11, 'h19, 'h1D, 'h0D: begin
                c = m_cmd[2]; h = m_cmd[3]; r = (m_cmd[4] + 1) & 255;
                if (r > SECT) begin
                    r = 1; h = (h + 1) & 255;
                    if (h == HDS) begin h = 0; c = (c + 1) & 255; if (c == CYLS) c = 0; end
                end
                m_st0 = 0; m_cyl = c; m_head = h; m_rec = r; m_num = m_cmd[5];
                m_res.push_back(0); m_res.push_back(0); m_res.push_back(0);
                m_res.push_back(c); m_res.push_back(h); m_res.push_back(r); m_res.push_back(m_num);
            end
            default: begin m_st0 = 'h80; m_res.push_back('h80); end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_res.delete();
            m_st0 = 0; m_cyl = 0; m_head = 0; m_rec = 0; m_num = 0;
            m_irq = 0; m_inrst = 0; m_drv = 0; m_motor = 0; m_dma = 0;
        end else begin
            m_sr = 0;
            if (wr_en && reg_sel == 2) begin
                m_drv = wr_data[1:0]; m_dma = wr_data[3]; m_motor = wr_data[7:4];
                if (wr_data[2]) begin
                    if (m_inrst) begin m_sr = 1; m_inrst = 0; m_irq = (wr_data[1:0] == 0); end
                end else if (!m_inrst) begin
                    m_inrst = 1; m_irq = 0;
                end
            end
            if (m_sr) begin
                m_phase = 0; m_cnt = 0; m_st0 = 0; m_res.delete();
            end else if (m_phase == 2) begin
                m_exec();
                m_phase = (m_res.size() != 0) ? 3 : 0;
            end else if (m_phase == 3) begin
                if (rd_en && reg_sel == 1) begin
                    void'(m_res.pop_front());
                    if (m_res.size() == 0) m_phase = 0;
                end
            end else if (wr_en && reg_sel == 1) begin
                if (m_phase == 0) begin m_opc = wr_data & 'h1F; m_lens(m_opc); m_cnt = 0; end
                m_cmd[m_cnt] = wr_data;
                m_cnt++;
                if (m_cnt == m_wlen) begin m_phase = 2; m_cnt = 0; end
                else m_phase = 1;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 drv_sel", drv_sel, m_drv);
            chk("R7 motor_on", motor_on, m_motor);
            chk("R7 dma_irq_en", dma_irq_en, m_dma);
            chk("R8 irq", irq, m_irq);
            case (reg_sel)
                2'd0: chk("R4 status", rd_data, (m_phase != 2 ? 'h80 : 0) | (m_phase == 3 ? 'h40 : 0));
                2'd1: chk("R5 data", rd_data, (m_phase == 3) ? m_res[0] : 0);
                2'd2: chk("R7 ctrl read", rd_data, 0);
                default: chk("R8 irq status", rd_data, m_irq ? 'hC0 : 0);
            endcase
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(int sel, int d);
        @(posedge clk); #2;
        reg_sel = 2'(sel); wr_en = 1'b1; wr_data = 8'(d);
        @(posedge clk); #2;
        wr_en = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic bus_rd(int sel, output int v);
        @(posedge clk); #2;
        reg_sel = 2'(sel); rd_en = 1'b1;
        @(negedge clk);
        v = rd_data;
        @(posedge clk); #2;
        rd_en = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic st_now(string req, int exp);
        #5;
        chk(req, rd_data, exp);
    endtask

    task automatic rd_seq(string req, int cnt, int e[7]);
        int v;
        bus_rd(0, v);
        chk({req, " result status"}, v, 'hC0);
        for (int i = 0; i < cnt; i++) begin
            bus_rd(1, v);
            chk(req, v, e[i]);
        end
        bus_rd(0, v);
        chk({req, " idle after results"}, v, 'h80);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int v;
        int ev[7];
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        bus_rd(0, v); chk("R1 status", v, 'h80);
        bus_rd(3, v); chk("R1 irq status", v, 'h00);
        chk("R1 irq", irq, 0);
        chk("R1 outputs", {drv_sel, motor_on, dma_irq_en}, 0);

        // R7/R8 control byte: enter reset, then release on drive 0
        bus_wr(2, 'h00);
        chk("R8 irq low in reset", irq, 0);
        bus_wr(2, 'h1C);
        bus_rd(3, v); chk("R8 irq status pending", v, 'hC0);
        chk("R7 motor", motor_on, 1);
        chk("R7 dma", dma_irq_en, 1);
        bus_rd(2, v); chk("R7 ctrl reads zero", v, 0);

        // R10 seek, status after every byte (R3, R4)
        bus_wr(1, 'h0F); st_now("R3 status after byte 0", 'h80);
        bus_wr(1, 'h04); st_now("R3 status after byte 1", 'h80);
        bus_wr(1, 'h05); st_now("R4 exec status", 'h00);
        bus_rd(0, v); chk("R4 no-result idle status", v, 'h80);

        // R10 sense interrupt
        bus_wr(1, 'h08); st_now("R4 exec status", 'h00);
        ev = '{'h20, 5, 0, 0, 0, 0, 0}; rd_seq("R10 sense-int", 2, ev);

        // R9 invalid opcodes
        bus_wr(1, 'h1F);
        ev = '{'h80, 0, 0, 0, 0, 0, 0}; rd_seq("R9 invalid 0x1F", 1, ev);
        // R2 upper bits ignored: 0xE8 acts as sense interrupt
        bus_wr(1, 'hE8);
        ev = '{'h80, 5, 0, 0, 0, 0, 0}; rd_seq("R2 opcode 0xE8", 2, ev);
        bus_wr(1, 'h00);
        ev = '{'h80, 0, 0, 0, 0, 0, 0}; rd_seq("R9 invalid 0x00", 1, ev);

        // R10 recalibrate then sense interrupt, with a write during results (R6)
        bus_wr(1, 'h07); bus_wr(1, 'h00);
        bus_wr(1, 'h08);
        bus_wr(1, 'h0F);
        ev = '{'hA0, 0, 0, 0, 0, 0, 0}; rd_seq("R6 write in result ignored / R10 recal", 2, ev);

        // R6 data read while idle
        bus_rd(1, v); chk("R6 idle data read", v, 0);
        bus_rd(0, v); chk("R6 status unchanged", v, 'h80);

        // R11 transfer with full wrap
        bus_wr(1, 'h46); bus_wr(1, 'h00); bus_wr(1, 2); bus_wr(1, 1); bus_wr(1, 4);
        bus_wr(1, 2); bus_wr(1, 4); bus_wr(1, 'h1B); bus_wr(1, 'hFF);
        ev = '{0, 0, 0, 0, 0, 1, 2}; rd_seq("R11 xfer wrap", 7, ev);
        bus_wr(1, 'h05); bus_wr(1, 'h00); bus_wr(1, 1); bus_wr(1, 0); bus_wr(1, 2);
        bus_wr(1, 2); bus_wr(1, 4); bus_wr(1, 'h1B); bus_wr(1, 'hFF);
        ev = '{0, 0, 0, 1, 0, 3, 2}; rd_seq("R11 xfer plain", 7, ev);
        bus_wr(1, 'h0A); bus_wr(1, 'h00);
        ev = '{0, 0, 0, 1, 0, 3, 2}; rd_seq("R11 read-id", 7, ev);
        bus_wr(1, 'h4D); bus_wr(1, 'h00); bus_wr(1, 0); bus_wr(1, 1); bus_wr(1, 4); bus_wr(1, 3);
        ev = '{0, 0, 0, 1, 0, 1, 3}; rd_seq("R11 format", 7, ev);

        // R12 specify and sense drive status
        bus_wr(1, 'h03); bus_wr(1, 'hAF); bus_wr(1, 'h02); st_now("R12 specify exec", 'h00);
        bus_rd(0, v); chk("R12 specify no results", v, 'h80);
        bus_wr(1, 'h04); bus_wr(1, 'h01);
        ev = '{0, 0, 0, 0, 0, 0, 0}; rd_seq("R12 sense-drive", 1, ev);

        // R8 soft reset cancels a half-collected command, drive 1 keeps irq low
        bus_wr(1, 'h0F);
        bus_wr(2, 'h00); chk("R8 irq cleared", irq, 0);
        bus_wr(2, 'h05);
        chk("R8 no irq for drive 1", irq, 0);
        chk("R7 drv_sel", drv_sel, 1);
        bus_rd(0, v); chk("R8 status after soft reset", v, 'h80);
        bus_wr(1, 'h08);
        ev = '{0, 1, 0, 0, 0, 0, 0}; rd_seq("R8 st0 cleared", 2, ev);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule